// File: doc/BRIEF.md
# Command Strobe and Interrupt Latch Controller

This block sits behind a byte-wide write port of a data-acquisition controller. The written byte is never stored: each set bit fires a one-shot action and each clear bit does nothing. The actions are a conversion start, a board-wide register reset, a separate analog-output reset, a sample-FIFO pointer reset, and four per-source interrupt acknowledges. Any mix of bits in one write fires all the chosen actions together.

The block holds four interrupt request latches, for the analog, digital I/O, timer and DMA sources. A latch sets on its source event and stays set until its acknowledge bit is written, and the interrupt line is the OR of all four latches. Three small stubs stand in for logic that lies outside this block. A converter stub holds a busy flag for a fixed number of cycles. A FIFO pointer stub counts pushes. An analog-output level register can be loaded and reset. The board reset clears every register except the analog-output level.

Top module: `acq_cmd_ctrl`

## Requirements
- R1: Command byte bit positions are 7 start conversion, 6 board reset, 5 analog-output reset, 4 FIFO reset, 3 DMA acknowledge, 2 timer acknowledge, 1 digital I/O acknowledge, 0 analog acknowledge. A written 1 produces its strobe output (`conv_start`, `board_rst_pulse`, `ao_rst_pulse`, `fifo_rst_pulse`) as a one-cycle pulse in the cycle after the write edge. A written 0 has no effect.
- R2: Several 1 bits in one write perform all of their actions in the same cycle, and no other action is performed.
- R3: A start bit write begins a conversion only when `ext_trig_en` is 0. When `ext_trig_en` is 1 the start bit is ignored and a high `ext_trig` begins the conversion. When `ext_trig_en` is 0, `ext_trig` is ignored.
- R4: After an accepted start, `busy` is high for exactly CONV_CYCLES cycles. A start request while busy is ignored. `status` bit 7 equals `busy`, and `status` bits 3..0 equal the pending latches (bit 3 DMA, 2 timer, 1 digital I/O, 0 analog).
- R5: A board reset clears all latches, `busy`, FIFO depth and FIFO write address. It overrides any event, push or start in the same write, and it leaves `ao_level` unchanged.
- R6: An analog-output reset sets `ao_level` to mid-scale (2^(AO_W-1)) when `ao_midscale` is 1 and to 0 otherwise. It overrides an `ao_wr` in the same cycle.
- R7: A FIFO reset sets `fifo_depth` and `fifo_waddr` to 0 and overrides a push in the same cycle. A push raises the depth up to FIFO_DEPTH, and the write address wraps modulo FIFO_DEPTH.
- R8: An `irq_evt` bit sets its latch (bit 3 DMA, 2 timer, 1 digital I/O, 0 analog). The latch stays set until its acknowledge bit is written. `irq_line` is high while any latch is set.
- R9: If a source event and the acknowledge for the same latch arrive in the same cycle, the latch ends set.
- R10: Synchronous reset clears all strobes, latches, `busy` and the FIFO pointers, and loads `ao_level` from the `ao_midscale` selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command byte write strobe |
| wr_data | input | 8 | Command byte |
| ext_trig_en | input | 1 | 1 selects external trigger mode |
| ext_trig | input | 1 | External conversion trigger |
| ao_midscale | input | 1 | Analog-output reset level select |
| ao_wr | input | 1 | Load analog-output level |
| ao_wdata | input | AO_W | Analog-output level to load |
| fifo_push | input | 1 | Sample stored into FIFO |
| irq_evt | input | 4 | Interrupt source events |
| conv_start | output | 1 | Conversion start pulse |
| board_rst_pulse | output | 1 | Board reset pulse |
| ao_rst_pulse | output | 1 | Analog-output reset pulse |
| fifo_rst_pulse | output | 1 | FIFO reset pulse |
| busy | output | 1 | Conversion in progress |
| status | output | 8 | Status byte |
| irq_pending | output | 4 | Interrupt latch states |
| irq_line | output | 1 | Combined interrupt request |
| fifo_depth | output | $clog2(FIFO_DEPTH+1) | Stored sample count |
| fifo_waddr | output | $clog2(FIFO_DEPTH) | Next FIFO write address |
| ao_level | output | AO_W | Analog-output level |

## Verification
The bench builds the block with CONV_CYCLES = 4, FIFO_DEPTH = 8 and AO_W = 12. The short conversion lets the bench count the whole busy window and try a start request in the middle of it within a few cycles. The eight-entry FIFO lets a short push burst reach both depth saturation and write-address wraparound. The twelve-bit output gives a mid-scale value of 0x800, which differs clearly from both zero and a loaded value.

// File: rtl/acq_cmd_pkg.sv
package acq_cmd_pkg;

    localparam int IRQ_N = 4;

    // Bit order matches the command byte, MSB first.
    typedef struct packed {
        logic             start;
        logic             board_rst;
        logic             ao_rst;
        logic             fifo_rst;
        logic [IRQ_N-1:0] ack;
    } cmd_t;

    typedef struct packed {
        logic start;
        logic board_rst;
        logic ao_rst;
        logic fifo_rst;
    } strobe_t;

    typedef enum logic [1:0] {
        SRC_ADC = 2'd0,
        SRC_DIO = 2'd1,
        SRC_TMR = 2'd2,
        SRC_DMA = 2'd3
    } irq_src_e;

    function automatic cmd_t decode_cmd(input logic wr, input logic [7:0] d);
        return wr ? cmd_t'(d) : '0;
    endfunction

    function automatic logic [7:0] pack_status(input logic bsy, input logic [IRQ_N-1:0] pend);
        return {bsy, 3'b000, pend};
    endfunction

endpackage

// File: rtl/acq_cmd_decode.sv
module acq_cmd_decode
    import acq_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  logic [7:0] wr_data,
    input  logic    ext_mode,
    input  logic    ext_trig,
    input  logic    busy,
    output cmd_t    cmd_now,
    output logic    start_req,
    output strobe_t strobe_q
);
    cmd_t cmd_c;

    always_comb begin
        cmd_c = decode_cmd(wr_en, wr_data);
        // Board reset stops conversions, so it also blocks a start.
        start_req = !busy && !cmd_c.board_rst &&
                    (ext_mode ? ext_trig : cmd_c.start);
    end

    assign cmd_now = cmd_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= '0;
        end else begin
            strobe_q.start     <= start_req;
            strobe_q.board_rst <= cmd_c.board_rst;
            strobe_q.ao_rst    <= cmd_c.ao_rst;
            strobe_q.fifo_rst  <= cmd_c.fifo_rst;
        end
    end
endmodule

// File: rtl/acq_irq_latch.sv
module acq_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic set,
    input  logic ack,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst || kill)  q <= 1'b0;
        else if (set)     q <= 1'b1;
        else if (ack)     q <= 1'b0;
    end
endmodule

// File: rtl/acq_conv_stub.sv
module acq_conv_stub #(
    parameter int CONV_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CONV_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (start) begin
            busy   <= 1'b1;
            remain <= CW'(CONV_CYCLES - 1);
        end else if (busy) begin
            if (remain == '0) busy <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/acq_fifo_ptr_stub.sv
module acq_fifo_ptr_stub #(
    parameter int FIFO_DEPTH = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic kill,
    input  logic push,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] depth,
    output logic [$clog2(FIFO_DEPTH)-1:0]   waddr
);
    localparam int DW = $clog2(FIFO_DEPTH + 1);
    localparam int AW = $clog2(FIFO_DEPTH);

    logic full;
    assign full = (depth == DW'(FIFO_DEPTH));

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            depth <= '0;
            waddr <= '0;
        end else if (push && !full) begin
            depth <= depth + 1'b1;
            waddr <= (waddr == AW'(FIFO_DEPTH - 1)) ? '0 : waddr + 1'b1;
        end
    end
endmodule

// File: rtl/acq_ao_stub.sv
module acq_ao_stub #(
    parameter int AO_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            zero_req,
    input  logic            midscale,
    input  logic            wr,
    input  logic [AO_W-1:0] wdata,
    output logic [AO_W-1:0] level
);
    localparam logic [AO_W-1:0] MID = {1'b1, {(AO_W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst || zero_req) level <= midscale ? MID : '0;
        else if (wr)         level <= wdata;
    end
endmodule

// File: rtl/acq_cmd_ctrl.sv
module acq_cmd_ctrl
    import acq_cmd_pkg::*;
#(
    parameter int CONV_CYCLES = 16,
    parameter int FIFO_DEPTH  = 512,
    parameter int AO_W        = 12
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [7:0]                        wr_data,
    input  logic                              ext_trig_en,
    input  logic                              ext_trig,
    input  logic                              ao_midscale,
    input  logic                              ao_wr,
    input  logic [AO_W-1:0]                   ao_wdata,
    input  logic                              fifo_push,
    input  logic [3:0]                        irq_evt,
    output logic                              conv_start,
    output logic                              board_rst_pulse,
    output logic                              ao_rst_pulse,
    output logic                              fifo_rst_pulse,
    output logic                              busy,
    output logic [7:0]                        status,
    output logic [3:0]                        irq_pending,
    output logic                              irq_line,
    output logic [$clog2(FIFO_DEPTH+1)-1:0]   fifo_depth,
    output logic [$clog2(FIFO_DEPTH)-1:0]     fifo_waddr,
    output logic [AO_W-1:0]                   ao_level
);
    cmd_t    cmd_now;
    strobe_t strobe_q;
    logic    start_req;

    acq_cmd_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ext_mode (ext_trig_en),
        .ext_trig (ext_trig),
        .busy     (busy),
        .cmd_now  (cmd_now),
        .start_req(start_req),
        .strobe_q (strobe_q)
    );

    acq_conv_stub #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
        .clk  (clk),
        .rst  (rst),
        .kill (cmd_now.board_rst),
        .start(start_req),
        .busy (busy)
    );

    acq_fifo_ptr_stub #(.FIFO_DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .kill (cmd_now.board_rst || cmd_now.fifo_rst),
        .push (fifo_push),
        .depth(fifo_depth),
        .waddr(fifo_waddr)
    );

    acq_ao_stub #(.AO_W(AO_W)) u_ao (
        .clk     (clk),
        .rst     (rst),
        .zero_req(cmd_now.ao_rst),
        .midscale(ao_midscale),
        .wr      (ao_wr),
        .wdata   (ao_wdata),
        .level   (ao_level)
    );

    for (genvar k = 0; k < IRQ_N; k++) begin : g_latch
        acq_irq_latch u_latch (
            .clk (clk),
            .rst (rst),
            .kill(cmd_now.board_rst),
            .set (irq_evt[k]),
            .ack (cmd_now.ack[k]),
            .q   (irq_pending[k])
        );
    end

    assign conv_start      = strobe_q.start;
    assign board_rst_pulse = strobe_q.board_rst;
    assign ao_rst_pulse    = strobe_q.ao_rst;
    assign fifo_rst_pulse  = strobe_q.fifo_rst;
    assign irq_line        = |irq_pending;
    assign status          = pack_status(busy, irq_pending);
endmodule

// File: rtl/acq_cmd_ctrl_chk.sv
module acq_cmd_ctrl_chk #(
    parameter int FIFO_DEPTH = 512,
    parameter int AO_W       = 12
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            wr_en,
    input logic [7:0]                      wr_data,
    input logic                            ext_trig_en,
    input logic                            ext_trig,
    input logic                            ao_wr,
    input logic [3:0]                      irq_evt,
    input logic                            conv_start,
    input logic                            board_rst_pulse,
    input logic                            ao_rst_pulse,
    input logic                            fifo_rst_pulse,
    input logic                            busy,
    input logic [3:0]                      irq_pending,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_depth,
    input logic [$clog2(FIFO_DEPTH)-1:0]   fifo_waddr,
    input logic [AO_W-1:0]                 ao_level
);
    assert_fifo_strobe_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[4]) |=> fifo_rst_pulse);

    assert_ao_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_data[5]) |=> !ao_rst_pulse);

    assert_board_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[6]) |=> board_rst_pulse);

    assert_ext_ignores_sw_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[7] && ext_trig_en && !ext_trig) |=> !conv_start);

    assert_start_sets_busy_R4: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> busy);

    assert_no_start_while_busy_R4: assert property (@(posedge clk) disable iff (rst)
        busy |=> !conv_start);

    assert_board_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[6]) |=> (irq_pending == '0 && !busy && fifo_depth == '0));

    assert_board_keeps_ao_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[6] && !wr_data[5] && !ao_wr) |=> $stable(ao_level));

    assert_fifo_ptr_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[4]) |=> (fifo_waddr == '0 && fifo_depth == '0));

    for (genvar k = 0; k < 4; k++) begin : g_irq
        assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (irq_pending[k] && !(wr_en && (wr_data[k] || wr_data[6]))) |=> irq_pending[k]);

        assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
            (irq_evt[k] && !(wr_en && wr_data[6])) |=> irq_pending[k]);
    end
endmodule

bind acq_cmd_ctrl acq_cmd_ctrl_chk #(.FIFO_DEPTH(FIFO_DEPTH), .AO_W(AO_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_data        (wr_data),
    .ext_trig_en    (ext_trig_en),
    .ext_trig       (ext_trig),
    .ao_wr          (ao_wr),
    .irq_evt        (irq_evt),
    .conv_start     (conv_start),
    .board_rst_pulse(board_rst_pulse),
    .ao_rst_pulse   (ao_rst_pulse),
    .fifo_rst_pulse (fifo_rst_pulse),
    .busy           (busy),
    .irq_pending    (irq_pending),
    .fifo_depth     (fifo_depth),
    .fifo_waddr     (fifo_waddr),
    .ao_level       (ao_level)
);

// File: tb/acq_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module acq_cmd_ctrl_bench;
    localparam int CONV_CYCLES = 4;
    localparam int FIFO_DEPTH  = 8;
    localparam int AO_W        = 12;
    localparam int NVEC        = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic ext_trig_en = 1'b0;
    logic ext_trig = 1'b0;
    logic ao_midscale = 1'b1;
    logic ao_wr = 1'b0;
    logic [AO_W-1:0] ao_wdata = '0;
    logic fifo_push = 1'b0;
    logic [3:0] irq_evt = '0;
    logic conv_start, board_rst_pulse, ao_rst_pulse, fifo_rst_pulse, busy, irq_line;
    logic [7:0] status;
    logic [3:0] irq_pending;
    logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_depth;
    logic [$clog2(FIFO_DEPTH)-1:0]   fifo_waddr;
    logic [AO_W-1:0] ao_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    acq_cmd_ctrl #(.CONV_CYCLES(CONV_CYCLES), .FIFO_DEPTH(FIFO_DEPTH), .AO_W(AO_W)) u_acq_cmd_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .ext_trig_en(ext_trig_en), .ext_trig(ext_trig), .ao_midscale(ao_midscale),
        .ao_wr(ao_wr), .ao_wdata(ao_wdata), .fifo_push(fifo_push), .irq_evt(irq_evt),
        .conv_start(conv_start), .board_rst_pulse(board_rst_pulse),
        .ao_rst_pulse(ao_rst_pulse), .fifo_rst_pulse(fifo_rst_pulse), .busy(busy),
        .status(status), .irq_pending(irq_pending), .irq_line(irq_line),
        .fifo_depth(fifo_depth), .fifo_waddr(fifo_waddr), .ao_level(ao_level)
    );

    // {evt[3:0], ext_mode, cmd[7:0], strobes{start,board,ao,fifo}, pending[3:0]}
    localparam logic [20:0] VECS [NVEC] = '{
        {4'hF, 1'b0, 8'h00, 4'b0000, 4'hF},
        {4'hF, 1'b0, 8'h01, 4'b0000, 4'hE},
        {4'hF, 1'b0, 8'h0A, 4'b0000, 4'h5},
        {4'hF, 1'b0, 8'h10, 4'b0001, 4'hF},
        {4'hF, 1'b0, 8'h80, 4'b1000, 4'hF},
        {4'hF, 1'b1, 8'h80, 4'b0000, 4'hF},
        {4'hF, 1'b0, 8'h40, 4'b0100, 4'h0},
        {4'hF, 1'b0, 8'h20, 4'b0010, 4'hF},
        {4'hF, 1'b0, 8'hF0, 4'b0111, 4'h0},
        {4'h5, 1'b0, 8'hFF, 4'b0111, 4'h0},
        {4'h3, 1'b0, 8'h8C, 4'b1000, 4'h3},
        {4'hF, 1'b0, 8'h2F, 4'b0010, 4'h0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_cmd(input logic [7:0] b);
        wr_en   = 1'b1;
        wr_data = b;
        tick();
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R10 reset state
        chk("R10 strobes", {conv_start, board_rst_pulse, ao_rst_pulse, fifo_rst_pulse}, 0);
        chk("R10 pending", irq_pending, 0);
        chk("R10 busy", busy, 0);
        chk("R10 fifo depth", fifo_depth, 0);
        chk("R10 ao level", ao_level, 12'h800);
        chk("R10 status", status, 0);

        // R1 R2 R3 R5 R8 vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [20:0] v;
            v = VECS[i];
            write_cmd(8'h0F);
            irq_evt     = v[20:17];
            ext_trig_en = v[16];
            tick();
            irq_evt = '0;
            write_cmd(v[15:8]);
            chk($sformatf("R1/R2 strobes vec %0d", i),
                {conv_start, board_rst_pulse, ao_rst_pulse, fifo_rst_pulse}, int'(v[7:4]));
            chk($sformatf("R8 pending vec %0d", i), irq_pending, int'(v[3:0]));
            chk($sformatf("R8 irq_line vec %0d", i), irq_line, int'(|v[3:0]));
            ext_trig_en = 1'b0;
            repeat (CONV_CYCLES + 2) tick();
        end

        // R4 busy window and start while busy
        write_cmd(8'h0F);
        write_cmd(8'h80);
        chk("R4 start pulse", conv_start, 1);
        chk("R4 status busy", status, 8'h80);
        n = 1;
        write_cmd(8'h80);
        chk("R4 start ignored while busy", conv_start, 0);
        if (busy) n++;
        for (int i = 0; i < 20 && busy; i++) begin
            tick();
            if (busy) n++;
        end
        chk("R4 busy length", n, CONV_CYCLES);
        irq_evt = 4'b1000;
        tick();
        irq_evt = '0;
        chk("R4 status pending bits", status, 8'h08);
        write_cmd(8'h08);

        // R3 external trigger
        ext_trig = 1'b1;
        tick();
        ext_trig = 1'b0;
        chk("R3 ext_trig ignored in sw mode", conv_start, 0);
        ext_trig_en = 1'b1;
        ext_trig = 1'b1;
        tick();
        ext_trig = 1'b0;
        chk("R3 ext trigger start", conv_start, 1);
        chk("R3 ext trigger busy", busy, 1);
        ext_trig_en = 1'b0;
        repeat (CONV_CYCLES + 2) tick();

        // R5 board reset aborts conversion
        write_cmd(8'h80);
        write_cmd(8'h40);
        chk("R5 busy cleared", busy, 0);

        // R7 FIFO pointers
        fifo_push = 1'b1;
        repeat (3) tick();
        fifo_push = 1'b0;
        chk("R7 depth after 3", fifo_depth, 3);
        chk("R7 waddr after 3", fifo_waddr, 3);
        fifo_push = 1'b1;
        write_cmd(8'h10);
        fifo_push = 1'b0;
        chk("R7 reset beats push", fifo_depth, 0);
        fifo_push = 1'b1;
        repeat (9) tick();
        fifo_push = 1'b0;
        chk("R7 depth saturates", fifo_depth, FIFO_DEPTH);
        chk("R7 waddr wraps", fifo_waddr, 0);
        write_cmd(8'h40);
        chk("R5 fifo cleared by board reset", fifo_depth, 0);

        // R5 R6 analog-output level
        ao_wr = 1'b1;
        ao_wdata = 12'h123;
        tick();
        ao_wr = 1'b0;
        write_cmd(8'h40);
        chk("R5 ao unchanged by board reset", ao_level, 12'h123);
        ao_midscale = 1'b0;
        write_cmd(8'h20);
        chk("R6 ao zero-scale", ao_level, 0);
        ao_midscale = 1'b1;
        ao_wr = 1'b1;
        ao_wdata = 12'h456;
        write_cmd(8'h20);
        ao_wr = 1'b0;
        chk("R6 ao mid-scale beats load", ao_level, 12'h800);

        // R9 set wins, R8 hold
        irq_evt = 4'b0100;
        write_cmd(8'h04);
        irq_evt = '0;
        chk("R9 set wins over ack", irq_pending, 4'b0100);
        repeat (5) tick();
        write_cmd(8'h00);
        chk("R8 latch holds", irq_pending, 4'b0100);
        chk("R8 irq_line held", irq_line, 1);
        write_cmd(8'h04);
        chk("R8 ack clears", irq_pending, 0);
        chk("R8 irq_line low", irq_line, 0);
        irq_evt = 4'hF;
        write_cmd(8'h40);
        irq_evt = '0;
        chk("R5 board reset beats event", irq_pending, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule